// File: doc/BRIEF.md
# Login Payload Checker with Response Pattern

This block sits behind a bit demodulator on the transponder side of a low-frequency link. Once a login command has been recognised, a start pulse arms the block. It then takes the serial password payload one bit at a time, on a single-cycle valid strobe.

The payload is four data bytes. Each byte is followed by an even-parity bit, then a column-parity byte, then a closing zero. Every parity check runs as soon as the deciding bit arrives. The first mismatch ends the reception at once, and later bits are ignored. The captured password is compared with a stored password supplied on a port.

When the reception ends, the block raises a result flag and a pass flag. It then drives a modulation output with either an acknowledge or a not-acknowledge pattern, measured in carrier periods, followed by a silent processing pause.

Top module: `login_checker`

## Requirements
- R1: After reset, `valid_o`, `pass_o`, `busy_o`, `mod_o` and `pw_o` are all zero.
- R2: Data bits are shifted into `pw_o` MSB first: the first received bit ends up in bit 31. Each group of 8 data bits is followed by a parity bit that must equal the XOR of that byte's bits.
- R3: A byte-parity mismatch ends the reception immediately, with `pass_o` low and the not-acknowledge pattern.
- R4: After the fourth byte's parity bit, 8 column-parity bits arrive MSB first. As an 8-bit value they must equal the XOR of the four received bytes; otherwise the reception fails.
- R5: The bit after the column parity must be 0; a 1 fails the reception.
- R6: After the reception has ended, passed or failed, strobed bits change nothing, including `pw_o`, until the next `start_i`.
- R7: `pw_match_o` is high exactly when `pw_o` equals `stored_pw_i`, with no clock delay.
- R8: `valid_o` rises on the second rising clock edge after the deciding bit's strobe is sampled. `pass_o` is high only if every check succeeded and `pw_o` equals `stored_pw_i`.
- R9: On pass, `mod_o` rises together with `valid_o` and plays, in carrier periods of `CARRIER_DIV` clocks each: 32 high, 32 low, 96 high, 32 low, 96 high, 32 low.
- R10: On fail, the pattern is the same, except that both 96-period high segments last 32 periods.
- R11: A 64-period pause with `mod_o` low follows the pattern. `busy_o` is high from the first pattern segment until the pause ends.
- R12: `start_i` clears `valid_o`, `pass_o` and `pw_o`, aborts any response (`busy_o` and `mod_o` low on the next cycle), and restarts reception from the first data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms a new reception; aborts any response |
| bit_i | input | 1 | Received payload bit |
| bit_valid_i | input | 1 | One-cycle strobe qualifying `bit_i` |
| stored_pw_i | input | 32 | Reference password |
| pw_o | output | 32 | Captured password bits |
| pw_match_o | output | 1 | `pw_o` equals `stored_pw_i` |
| valid_o | output | 1 | Reception finished, result held |
| pass_o | output | 1 | All checks passed and password matched |
| busy_o | output | 1 | Response pattern or pause in progress |
| mod_o | output | 1 | Modulation output |

## Verification
The checker is driven with these payloads:
- a clean payload that matches the stored password;
- the same clean payload against a different stored password;
- a payload with a corrupted second-byte parity;
- a payload with a flipped column-parity bit;
- a payload with a trailing one.

The matching and non-matching clean payloads separate a parity failure from a password mismatch: both give the not-acknowledge pattern, but only a parity failure leaves a partial `pw_o`. The three corrupted payloads show that each check fires at its own bit, at the right cycle, and that the bits after it are ignored. A start pulse in the middle of an acknowledge, followed by a fresh payload, shows both the abort and the restart.

// File: rtl/login_chk_pkg.sv
package login_chk_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_DATA,
    RX_BPAR,
    RX_COLP,
    RX_ZERO
  } rx_state_e;

  localparam int unsigned RESP_SEGS = 7;  // six pattern segments plus pause
endpackage

// File: rtl/login_rx.sv
module login_rx
  import login_chk_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  parameter int unsigned BITS  = 8,
  localparam int unsigned PW_W = BYTES * BITS,
  localparam int unsigned CW   = $clog2(BITS),
  localparam int unsigned BW   = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            bit_i,
  input  logic            bit_valid_i,
  output logic [PW_W-1:0] pw_o,
  output logic            done_o,
  output logic            ok_o
);
  rx_state_e       st_q;
  logic [PW_W-1:0] pw_q;
  logic [CW-1:0]   cnt_q;
  logic [BW-1:0]   byte_q;
  logic            par_q;
  logic [BITS-1:0] col_q;
  logic [BITS-1:0] col_exp;
  logic [BITS-1:0] col_nxt;
  logic            done_q, ok_q;

  always_comb begin
    col_exp = '0;
    for (int i = 0; i < BYTES; i++) col_exp ^= pw_q[i*BITS +: BITS];
  end

  assign col_nxt = {col_q[BITS-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      pw_q   <= '0;
      cnt_q  <= '0;
      byte_q <= '0;
      par_q  <= 1'b0;
      col_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        st_q   <= RX_DATA;
        pw_q   <= '0;
        cnt_q  <= '0;
        byte_q <= '0;
        par_q  <= 1'b0;
        col_q  <= '0;
        ok_q   <= 1'b0;
      end else if (bit_valid_i) begin
        unique case (st_q)
          RX_DATA: begin
            pw_q  <= {pw_q[PW_W-2:0], bit_i};
            par_q <= par_q ^ bit_i;
            if (cnt_q == CW'(BITS - 1)) begin
              cnt_q <= '0;
              st_q  <= RX_BPAR;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_BPAR: begin
            if (bit_i != par_q) begin
              st_q   <= RX_IDLE;
              done_q <= 1'b1;
              ok_q   <= 1'b0;
            end else begin
              par_q <= 1'b0;
              if (byte_q == BW'(BYTES - 1)) begin
                byte_q <= '0;
                st_q   <= RX_COLP;
              end else begin
                byte_q <= byte_q + 1'b1;
                st_q   <= RX_DATA;
              end
            end
          end
          RX_COLP: begin
            col_q <= col_nxt;
            if (cnt_q == CW'(BITS - 1)) begin
              cnt_q <= '0;
              if (col_nxt == col_exp) begin
                st_q <= RX_ZERO;
              end else begin
                st_q   <= RX_IDLE;
                done_q <= 1'b1;
                ok_q   <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_ZERO: begin
            st_q   <= RX_IDLE;
            done_q <= 1'b1;
            ok_q   <= ~bit_i;
          end
          default: ;
        endcase
      end
    end
  end

  assign pw_o   = pw_q;
  assign done_o = done_q;
  assign ok_o   = ok_q;

  // R6: an idle receiver keeps the captured value
  a_r6_idle_holds_pw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_IDLE && !start_i) |=> $stable(pw_q));

  // R5: the closing-bit state is entered only from column parity
  a_r5_zero_after_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_ZERO) |-> ($past(st_q) == RX_COLP || $past(st_q) == RX_ZERO));

  // R8: one end-of-reception pulse per reception
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/login_resp.sv
module login_resp
  import login_chk_pkg::*;
#(
  parameter int unsigned CARRIER_DIV = 4,
  parameter int unsigned SHORT_SEG   = 32,
  parameter int unsigned LONG_SEG    = 96,
  parameter int unsigned PAUSE_SEG   = 64,
  localparam int unsigned MAX_SEG = (LONG_SEG > PAUSE_SEG)
                                    ? ((LONG_SEG > SHORT_SEG) ? LONG_SEG : SHORT_SEG)
                                    : ((PAUSE_SEG > SHORT_SEG) ? PAUSE_SEG : SHORT_SEG),
  localparam int unsigned LW = $clog2(MAX_SEG + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic go_i,
  input  logic ack_i,
  output logic busy_o,
  output logic mod_o
);
  localparam logic [2:0] LAST_SEG = 3'(RESP_SEGS - 1);

  logic          busy_q, ack_q, tick;
  logic [2:0]    seg_q;
  logic [LW-1:0] cnt_q, seg_len;

  generate
    if (CARRIER_DIV == 1) begin : g_no_div
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(CARRIER_DIV);
      logic [PW-1:0] pre_q;
      assign tick = (pre_q == PW'(CARRIER_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else if (abort_i || go_i || tick || !busy_q) pre_q <= '0;
        else pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate

  always_comb begin
    unique case (seg_q)
      3'd2, 3'd4: seg_len = ack_q ? LW'(LONG_SEG) : LW'(SHORT_SEG);
      LAST_SEG:   seg_len = LW'(PAUSE_SEG);
      default:    seg_len = LW'(SHORT_SEG);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
      seg_q  <= '0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      seg_q  <= '0;
      cnt_q  <= '0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      ack_q  <= ack_i;
      seg_q  <= '0;
      cnt_q  <= '0;
    end else if (busy_q && tick) begin
      if (cnt_q == seg_len - 1'b1) begin
        cnt_q <= '0;
        if (seg_q == LAST_SEG) busy_q <= 1'b0;
        else seg_q <= seg_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // even segments are loaded, odd segments and the pause are not
  assign mod_o  = busy_q && !seg_q[0] && (seg_q != LAST_SEG);
  assign busy_o = busy_q;

  // R10: segment counter stays inside the selected segment length
  a_r10_cnt_in_seg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < seg_len));

  // R11: a normally completed response ends in the unloaded pause
  a_r11_end_unloaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_q) && !$past(abort_i)) |-> !$past(mod_o));
endmodule

// File: rtl/login_checker.sv
module login_checker #(
  parameter int unsigned BYTES       = 4,
  parameter int unsigned BITS        = 8,
  parameter int unsigned CARRIER_DIV = 4,
  parameter int unsigned SHORT_SEG   = 32,
  parameter int unsigned LONG_SEG    = 96,
  parameter int unsigned PAUSE_SEG   = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    bit_i,
  input  logic                    bit_valid_i,
  input  logic [BYTES*BITS-1:0]   stored_pw_i,
  output logic [BYTES*BITS-1:0]   pw_o,
  output logic                    pw_match_o,
  output logic                    valid_o,
  output logic                    pass_o,
  output logic                    busy_o,
  output logic                    mod_o
);
  localparam int unsigned PW_W = BYTES * BITS;

  logic [PW_W-1:0] rx_pw;
  logic            rx_done, rx_ok, grant;
  logic            valid_q, pass_q;

  login_rx #(.BYTES(BYTES), .BITS(BITS)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .bit_i      (bit_i),
    .bit_valid_i(bit_valid_i),
    .pw_o       (rx_pw),
    .done_o     (rx_done),
    .ok_o       (rx_ok)
  );

  assign pw_match_o = (rx_pw == stored_pw_i);
  assign grant      = rx_ok && pw_match_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else if (start_i) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else if (rx_done) begin
      valid_q <= 1'b1;
      pass_q  <= grant;
    end
  end

  login_resp #(
    .CARRIER_DIV(CARRIER_DIV),
    .SHORT_SEG  (SHORT_SEG),
    .LONG_SEG   (LONG_SEG),
    .PAUSE_SEG  (PAUSE_SEG)
  ) u_resp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(start_i),
    .go_i   (rx_done && !start_i),
    .ack_i  (grant),
    .busy_o (busy_o),
    .mod_o  (mod_o)
  );

  assign pw_o    = rx_pw;
  assign valid_o = valid_q;
  assign pass_o  = pass_q;

  // R8: pass is only ever shown with a result
  a_r8_pass_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> valid_o);

  // R9: the response starts in the same cycle the result appears
  a_r9_resp_with_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $rose(valid_o));

  // R12: start clears result and response
  a_r12_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!valid_o && !busy_o && !mod_o));
endmodule

// File: tb/login_checker_bench.sv
`timescale 1ns/1ps
module login_checker_bench;
  localparam int DIV = 4;
  localparam int NB  = 45;

  typedef struct packed {
    logic        pass;
    logic [31:0] pw;
    logic        ack;
    logic        aborted;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        bit_d = 1'b0;
  logic        bit_v = 1'b0;
  logic [31:0] stored = '0;
  logic [31:0] pw;
  logic        pw_match, valid, pass, busy, mod;

  int   checks = 0;
  int   fails = 0;
  bit   done_flag = 1'b0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  login_checker u_login_checker (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .bit_i      (bit_d),
    .bit_valid_i(bit_v),
    .stored_pw_i(stored),
    .pw_o       (pw),
    .pw_match_o (pw_match),
    .valid_o    (valid),
    .pass_o     (pass),
    .busy_o     (busy),
    .mod_o      (mod)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops expected item at each new result and measures the pattern
  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (valid && !prev) begin
        exp_t e;
        int   run[8];
        int   ri, total, lng;
        logic lvl;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", 1, 0);
          e = '0;
        end else begin
          e = exp_q.pop_front();
        end
        chk(pass == e.pass, "R8 pass_o", pass, e.pass);
        chk(pw == e.pw, "R2 pw_o", pw, e.pw);
        chk(mod == 1'b1, "R9 mod_o rises with valid_o", mod, 1);
        foreach (run[i]) run[i] = 0;
        ri = 0; total = 0; lvl = mod;
        while (busy) begin
          if (mod != lvl) begin
            if (ri < 7) ri++;
            lvl = mod;
          end
          run[ri]++;
          total++;
          @(negedge clk);
        end
        if (!e.aborted) begin
          lng = e.ack ? 96 : 32;
          chk(ri == 5, "R9 segment count", ri, 5);
          chk(run[0] == 32*DIV && run[1] == 32*DIV && run[3] == 32*DIV,
              e.ack ? "R9 short segments" : "R10 short segments", run[0], 32*DIV);
          chk(run[2] == lng*DIV && run[4] == lng*DIV,
              e.ack ? "R9 long high segments" : "R10 shortened high segments", run[2], lng*DIV);
          chk(run[5] == (32+64)*DIV, "R11 last low plus pause", run[5], (32+64)*DIV);
          chk(total == (e.ack ? 384 : 256)*DIV, "R11 busy_o length", total, (e.ack ? 384 : 256)*DIV);
        end
      end
      prev = valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // mode 0 clean, 1 bad parity on byte 1, 2 bad column parity, 3 trailing one
  task automatic run_payload(input logic [31:0] val, input int mode, input bit aborted);
    logic bits[NB];
    int   idx, dec;
    logic [7:0] by, col;
    logic par;
    exp_t e;
    idx = 0;
    col = '0;
    for (int b = 0; b < 4; b++) begin
      by = val[31-8*b -: 8];
      col ^= by;
      for (int k = 7; k >= 0; k--) bits[idx++] = by[k];
      par = ^by;
      if (mode == 1 && b == 1) par = ~par;
      bits[idx++] = par;
    end
    if (mode == 2) col[0] = ~col[0];
    for (int k = 7; k >= 0; k--) bits[idx++] = col[k];
    bits[idx] = (mode == 3);
    dec = (mode == 1) ? 17 : (mode == 2) ? 43 : 44;
    e.pass    = (mode == 0) && (val == stored);
    e.ack     = e.pass;
    e.pw      = (mode == 1) ? {16'h0, val[31:16]} : val;
    e.aborted = aborted;
    exp_q.push_back(e);
    pulse_start();
    for (int i = 0; i < NB; i++) begin
      bit_d = bits[i];
      bit_v = 1'b1;
      @(negedge clk);
      bit_v = 1'b0;
      if (i == dec) chk(valid == 1'b0, "R8 valid_o not yet", valid, 0);
      @(negedge clk);
      if (i == dec) begin
        chk(valid == 1'b1, mode == 1 ? "R3 early fail timing" : "R8 valid_o timing", valid, 1);
      end
    end
    chk(pw == e.pw, "R6 pw_o after trailing bits", pw, e.pw);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 0 && pass == 0, "R1 result flags", {valid, pass}, 0);
    chk(busy == 0 && mod == 0, "R1 response idle", {busy, mod}, 0);
    chk(pw == 0, "R1 pw_o", pw, 0);

    // R2 R4 R5 R9 R11: clean payload matching stored value
    stored = 32'hA53C_0F96;
    run_payload(32'hA53C_0F96, 0, 1'b0);
    chk(pw_match == 1'b1, "R7 match high", pw_match, 1);
    stored = 32'hA53C_0F97;
    #1 chk(pw_match == 1'b0, "R7 match follows stored_pw_i", pw_match, 0);
    wait_idle();

    // R8 R10: clean payload, wrong password
    run_payload(32'h1234_5678, 0, 1'b0);
    chk(pass == 1'b0 && valid == 1'b1, "R8 mismatch rejects", {valid, pass}, 2);
    wait_idle();

    // R3 R6: corrupted byte parity
    stored = 32'hFF00_33CC;
    run_payload(32'hFF00_33CC, 1, 1'b0);
    wait_idle();

    // R4: flipped column parity bit
    run_payload(32'hFF00_33CC, 2, 1'b0);
    wait_idle();

    // R5: trailing one
    run_payload(32'hFF00_33CC, 3, 1'b0);
    wait_idle();

    // R12: abort during acknowledge, then a fresh reception
    run_payload(32'hFF00_33CC, 0, 1'b1);
    repeat (100) @(negedge clk);
    chk(busy == 1'b1, "R12 response running before abort", busy, 1);
    pulse_start();
    chk(valid == 0 && pass == 0, "R12 start clears result", {valid, pass}, 0);
    chk(busy == 0 && mod == 0, "R12 start aborts response", {busy, mod}, 0);
    chk(pw == 0, "R12 start clears pw_o", pw, 0);
    repeat (3) @(negedge clk);
    run_payload(32'hFF00_33CC, 0, 1'b0);
    chk(pass == 1'b1, "R12 restart passes", pass, 1);
    wait_idle();

    chk(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule